// File: doc/BRIEF.md
# Generation-Tagged Direct-Mapped Translation Buffer

This block caches linear-to-physical page translations for 32-bit linear addresses and 4 KiB pages. It is direct-mapped: the low bits of the linear page number choose one slot. A requester sends lookups on a valid/ready stream and receives one registered answer per accepted lookup. The answer gives the hit flag, the physical address and the permission verdict for the access. A second valid/ready stream installs translations. Each translation is a linear page, a physical frame and four permission bits.

Invalidating every entry normally takes one cycle. Each stored tag is the linear page number with a 12-bit generation value in its low bits. A flush steps that value down, so every older tag stops matching. Only when the value would reach zero does the block rewrite every tag with an all-ones marker. It does this one slot per cycle while `busy` is high, and then starts the generation value again. The marker cannot match any lookup because the generation value is never 0xFFF. The same one-slot-per-cycle rewrite also runs after reset.

The lookup stream never stalls: `req_ready` is always high and the response has no back-pressure. The fill stream is held off through `fill_ready` while `busy` is high. `flush_req` is a plain single-cycle control input.

Top module: `gtlb_top`

## Requirements
- R1: After reset, `busy` stays high for exactly 2^IDX_W cycles and `fill_ready` is low during that time. After it ends, every lookup misses until a slot is filled.
- R2: `req_ready` is always 1. An accepted lookup gives `rsp_valid` in exactly the next cycle, and only then.
- R3: The slot is chosen by linear address bits [12+IDX_W-1:12]. A lookup hits only if that slot was last filled with the same linear page (bits 31:12) under the current generation value. A fill to a slot replaces whatever page was there before.
- R4: On a hit, `rsp_paddr` is {stored frame, linear address bits 11:0}. On a miss it is zero.
- R5: `rsp_perm_ok` is stored permission bit number {req_write, req_priv} for a data access (`req_fetch`=0), and bit number req_priv for a fetch (`req_fetch`=1). It is 0 on a miss.
- R6: `req_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The lookup can hit only when offset + bytes <= 0x1000, so the limits are 0xFFF, 0xFFE, 0xFFC and 0xFF8. Any access past its limit misses.
- R7: When `busy` is low, a flush steps the generation value down by one. If the result is not zero, all earlier entries miss from the next lookup onward, and `busy` stays low.
- R8: The flush that would bring the generation value to zero instead raises `busy` for 2^IDX_W cycles, rewrites every tag as invalid and reloads the value to GEN_INIT (default 0xFFE). Entries filled under the reloaded value before that flush do not hit again.
- R9: While `busy` is high, every lookup misses and `flush_req` is ignored. A presented fill is not accepted, so it leaves no entry behind.
- R10: Several operations can share one cycle. A lookup then sees the slot contents and generation value from before that cycle's fill or flush. A fill sharing a cycle with a flush is tagged with the old generation value, so it is invalid at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup accepted (always 1) |
| req_laddr | input | LA_W | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Privilege bit of the access |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_size | input | 2 | Access size code (R6) |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | PA_W | Physical address |
| rsp_perm_ok | output | 1 | Access allowed by stored permission bits |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted (low while busy) |
| fill_lpage | input | LA_W-12 | Linear page number to install |
| fill_frame | input | PA_W-12 | Physical frame number |
| fill_perm | input | 4 | Permission bits |
| flush_req | input | 1 | Invalidate all entries |
| busy | output | 1 | Full tag rewrite in progress |

## Verification
The hard cases are a fill, a flush and a lookup that arrive in the same cycle. The bench drives these together on one falling edge: a lookup with a fill to the same slot, a lookup with a flush, and a fill with a flush. It then judges the answer returned in the next cycle, and the lookups that follow, against a model that applies a lookup before the fill or flush of its own cycle. The flush that wraps the generation value is placed so that old entries, filled under the value the counter returns to, would hit again if the slots were not rewritten.

// File: rtl/gtlb_pkg.sv
package gtlb_pkg;

  // 4 KiB pages: offset width, also the width of the generation value
  localparam int unsigned PG_OFF_W = 12;
  localparam int unsigned PERM_W   = 4;

  // Access size codes
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  // True when an access of the given size at this offset stays in its page
  function automatic logic fits_page(input logic [PG_OFF_W-1:0] off,
                                     input logic [1:0] sz);
    logic [PG_OFF_W:0] last_x;
    last_x = {1'b0, off} + ((PG_OFF_W+1)'(1) << sz);
    return last_x <= (PG_OFF_W+1)'(1 << PG_OFF_W);
  endfunction

  // Bit of the permission nibble that governs this access
  function automatic logic [1:0] perm_sel(input logic wr, input logic pv,
                                          input logic fe);
    return fe ? {1'b0, pv} : {wr, pv};
  endfunction

endpackage

// File: rtl/gtlb_gen.sv
// Generation counter and the sequencer that rewrites all tags
module gtlb_gen #(
  parameter int unsigned IDX_W = 10,
  parameter logic [gtlb_pkg::PG_OFF_W-1:0] GEN_INIT = 12'hFFE
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush_req,
  output logic [gtlb_pkg::PG_OFF_W-1:0]     gen_o,
  output logic                              busy_o,
  output logic [IDX_W-1:0]                  scrub_idx_o
);
  import gtlb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic [PG_OFF_W-1:0] gen_q;
  logic [PG_OFF_W-1:0] gen_dec;
  logic                busy_q;
  logic [IDX_W-1:0]    sidx_q;

  assign gen_dec = gen_q - PG_OFF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= GEN_INIT;
      busy_q <= 1'b1;
      sidx_q <= '0;
    end else if (busy_q) begin
      sidx_q <= sidx_q + IDX_W'(1);
      if (sidx_q == LAST_IDX) busy_q <= 1'b0;
    end else if (flush_req) begin
      if (gen_dec == '0) begin
        busy_q <= 1'b1;
        sidx_q <= '0;
        gen_q  <= GEN_INIT;
      end else begin
        gen_q  <= gen_dec;
      end
    end
  end

  assign gen_o       = gen_q;
  assign busy_o      = busy_q;
  assign scrub_idx_o = sidx_q;

endmodule

// File: rtl/gtlb_array.sv
// Tag, frame and permission storage with one write port and one registered read
module gtlb_array #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned TAG_W = 32,
  parameter int unsigned FR_W  = 20
) (
  input  logic                          clk,
  input  logic                          scrub_en,
  input  logic [IDX_W-1:0]              scrub_idx,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [FR_W-1:0]               wr_frame,
  input  logic [gtlb_pkg::PERM_W-1:0]   wr_perm,
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [FR_W-1:0]               rd_frame,
  output logic [gtlb_pkg::PERM_W-1:0]   rd_perm
);
  import gtlb_pkg::*;

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem   [DEPTH];
  logic [FR_W-1:0]   frame_mem [DEPTH];
  logic [PERM_W-1:0] perm_mem  [DEPTH];

  // The rewrite has priority; fills are held off while it runs
  always_ff @(posedge clk) begin
    if (scrub_en)   tag_mem[scrub_idx] <= '1;
    else if (wr_en) tag_mem[wr_idx]    <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !scrub_en) begin
      frame_mem[wr_idx] <= wr_frame;
      perm_mem[wr_idx]  <= wr_perm;
    end
  end

  // Read-before-write: same-edge fill is not visible to this read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag   <= tag_mem[rd_idx];
      rd_frame <= frame_mem[rd_idx];
      rd_perm  <= perm_mem[rd_idx];
    end
  end

endmodule

// File: rtl/gtlb_resp.sv
// Lookup stage: captures the request, then compares against the read slot
module gtlb_resp #(
  parameter int unsigned LA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_fire,
  input  logic [LA_W-1:0]                   req_laddr,
  input  logic                              req_write,
  input  logic                              req_priv,
  input  logic                              req_fetch,
  input  logic [1:0]                        req_size,
  input  logic                              busy,
  input  logic [gtlb_pkg::PG_OFF_W-1:0]     gen,
  input  logic [LA_W-1:0]                   rd_tag,
  input  logic [PA_W-gtlb_pkg::PG_OFF_W-1:0] rd_frame,
  input  logic [gtlb_pkg::PERM_W-1:0]       rd_perm,
  output logic                              rsp_valid,
  output logic                              rsp_hit,
  output logic [PA_W-1:0]                   rsp_paddr,
  output logic                              rsp_perm_ok
);
  import gtlb_pkg::*;

  localparam int unsigned PAGE_W = LA_W - PG_OFF_W;

  logic                vld_q;
  logic [PAGE_W-1:0]   page_q;
  logic [PG_OFF_W-1:0] off_q;
  logic [PG_OFF_W-1:0] gen_q;
  logic [1:0]          sel_q;
  logic                fits_q;
  logic                blk_q;
  logic                tag_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= req_fire;
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      page_q <= req_laddr[LA_W-1:PG_OFF_W];
      off_q  <= req_laddr[PG_OFF_W-1:0];
      gen_q  <= gen;
      sel_q  <= perm_sel(req_write, req_priv, req_fetch);
      fits_q <= fits_page(req_laddr[PG_OFF_W-1:0], req_size);
      blk_q  <= busy;
    end
  end

  assign tag_eq      = (rd_tag == {page_q, gen_q});
  assign rsp_valid   = vld_q;
  assign rsp_hit     = vld_q & ~blk_q & fits_q & tag_eq;
  assign rsp_perm_ok = rsp_hit & rd_perm[sel_q];
  assign rsp_paddr   = rsp_hit ? {rd_frame, off_q} : '0;

endmodule

// File: rtl/gtlb_top.sv
module gtlb_top #(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter logic [11:0] GEN_INIT = 12'hFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              req_fetch,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_perm_ok,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [LA_W-13:0]  fill_lpage,
  input  logic [PA_W-13:0]  fill_frame,
  input  logic [3:0]        fill_perm,
  input  logic              flush_req,
  output logic              busy
);
  import gtlb_pkg::*;

  localparam int unsigned FR_W = PA_W - PG_OFF_W;

  logic [PG_OFF_W-1:0] gen_w;
  logic                busy_w;
  logic [IDX_W-1:0]    scrub_idx_w;
  logic                fill_fire;
  logic                req_fire;
  logic [LA_W-1:0]     rd_tag_w;
  logic [FR_W-1:0]     rd_frame_w;
  logic [PERM_W-1:0]   rd_perm_w;

  assign req_ready  = 1'b1;
  assign req_fire   = req_valid;
  assign fill_ready = ~busy_w;
  assign fill_fire  = fill_valid & ~busy_w;
  assign busy       = busy_w;

  gtlb_gen #(.IDX_W(IDX_W), .GEN_INIT(GEN_INIT)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_req  (flush_req),
    .gen_o      (gen_w),
    .busy_o     (busy_w),
    .scrub_idx_o(scrub_idx_w)
  );

  gtlb_array #(.IDX_W(IDX_W), .TAG_W(LA_W), .FR_W(FR_W)) u_arr (
    .clk      (clk),
    .scrub_en (busy_w),
    .scrub_idx(scrub_idx_w),
    .wr_en    (fill_fire),
    .wr_idx   (fill_lpage[IDX_W-1:0]),
    .wr_tag   ({fill_lpage, gen_w}),
    .wr_frame (fill_frame),
    .wr_perm  (fill_perm),
    .rd_en    (req_fire),
    .rd_idx   (req_laddr[PG_OFF_W+IDX_W-1:PG_OFF_W]),
    .rd_tag   (rd_tag_w),
    .rd_frame (rd_frame_w),
    .rd_perm  (rd_perm_w)
  );

  gtlb_resp #(.LA_W(LA_W), .PA_W(PA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_laddr  (req_laddr),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .req_fetch  (req_fetch),
    .req_size   (req_size),
    .busy       (busy_w),
    .gen        (gen_w),
    .rd_tag     (rd_tag_w),
    .rd_frame   (rd_frame_w),
    .rd_perm    (rd_perm_w),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_paddr  (rsp_paddr),
    .rsp_perm_ok(rsp_perm_ok)
  );

endmodule

// File: rtl/gtlb_sva.sv
module gtlb_sva #(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter logic [11:0] GEN_INIT = 12'hFFE
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [LA_W-1:0] req_laddr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_perm_ok,
  input logic            fill_ready,
  input logic            flush_req,
  input logic            busy,
  input logic [11:0]     gen
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + (IDX_W+1)'(1);
    else           bcnt <= '0;
  end

  // R1 / R8: every rewrite lasts exactly DEPTH cycles
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == (IDX_W+1)'(DEPTH));

  // R2: answer in the cycle after acceptance, and only then
  p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4: offset passes through on a hit, zero address on a miss
  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[11:0] == $past(req_laddr[11:0]));
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

  // R5: permission verdict only with a hit
  p_perm_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perm_ok |-> rsp_hit);

  // R7: ordinary flush steps the generation value by one
  p_gen_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy && gen > 12'd1) |=> (!busy && gen == $past(gen) - 12'd1));

  // R8: wrapping flush starts a rewrite and reloads the value
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy && gen == 12'd1) |=> (busy && gen == GEN_INIT));

  // R8: the value never reaches zero or the invalid marker
  p_gen_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen != 12'd0 && gen <= GEN_INIT);

  // R9: no fills and no hits while rewriting; flush is ignored
  p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fill_ready);
  p_busy_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(busy)) |-> !rsp_hit);
  p_busy_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flush_req) |=> $stable(gen));

endmodule

bind gtlb_top gtlb_sva #(.LA_W(LA_W), .PA_W(PA_W), .IDX_W(IDX_W), .GEN_INIT(GEN_INIT)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_laddr  (req_laddr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_paddr  (rsp_paddr),
  .rsp_perm_ok(rsp_perm_ok),
  .fill_ready (fill_ready),
  .flush_req  (flush_req),
  .busy       (busy),
  .gen        (gen_w)
);

// File: tb/sim_gtlb_top.sv
module sim_gtlb_top;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [11:0] GINIT = 12'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0, req_priv = 1'b0, req_fetch = 1'b0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid, rsp_hit, rsp_perm_ok;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_lpage = '0, fill_frame = '0;
  logic [3:0]  fill_perm = '0;
  logic        flush_req = 1'b0;
  logic        busy;

  always #4 clk = ~clk;

  gtlb_top #(.IDX_W(IDX_W), .GEN_INIT(GINIT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_write(req_write), .req_priv(req_priv), .req_fetch(req_fetch),
    .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_perm_ok(rsp_perm_ok),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_lpage(fill_lpage),
    .fill_frame(fill_frame), .fill_perm(fill_perm),
    .flush_req(flush_req), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc    = 0;

  // Reference state
  logic [31:0] m_tag   [DEPTH];
  logic [19:0] m_frame [DEPTH];
  logic [3:0]  m_perm  [DEPTH];
  int          m_gen;
  bit          m_busy;
  int          m_cnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pg(input int i, input int k);
    return 20'h12340 + 20'(k * DEPTH) + 20'(i);
  endfunction

  function automatic logic [19:0] fr(input int i, input int k);
    return 20'hF0000 ^ 20'(i * 20'h111) ^ 20'(k << 8);
  endfunction

  // One clock edge; called and returning at a falling edge
  task automatic step(input bit lk, input logic [31:0] la, input bit wr, input bit pv,
                      input bit fe, input logic [1:0] sz,
                      input bit fl, input logic [19:0] fpg, input logic [19:0] ffr,
                      input logic [3:0] fpm, input bit fls, input string req);
    logic [31:0] e_paddr;
    bit          e_hit, e_ok, fits;
    int          idx, bytes, sel;
    chk("R1/R9 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R1/R9 fill_ready", {31'd0, fill_ready}, {31'd0, !m_busy});
    chk("R2 req_ready", {31'd0, req_ready}, 32'd1);
    req_valid = lk; req_laddr = la; req_write = wr; req_priv = pv;
    req_fetch = fe; req_size = sz;
    fill_valid = fl; fill_lpage = fpg; fill_frame = ffr; fill_perm = fpm;
    flush_req = fls;
    idx   = int'(la[12 +: IDX_W]);
    bytes = 1 << sz;
    fits  = (int'(la[11:0]) + bytes) <= 4096;
    e_hit = !m_busy && fits && (m_tag[idx] == {la[31:12], 12'(m_gen)});
    sel   = fe ? int'(pv) : int'({wr, pv});
    e_ok  = e_hit && m_perm[idx][sel];
    e_paddr = e_hit ? {m_frame[idx], la[11:0]} : 32'd0;
    // model update: fill and flush use the state from before this edge
    if (fl && !m_busy) begin
      m_tag[int'(fpg[IDX_W-1:0])]   = {fpg, 12'(m_gen)};
      m_frame[int'(fpg[IDX_W-1:0])] = ffr;
      m_perm[int'(fpg[IDX_W-1:0])]  = fpm;
    end
    if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) m_busy = 0;
    end else if (fls) begin
      if (m_gen == 1) begin
        m_busy = 1; m_cnt = DEPTH; m_gen = int'(GINIT);
        for (int j = 0; j < DEPTH; j++) m_tag[j] = '1;
      end else begin
        m_gen--;
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; fill_valid = 0; flush_req = 0;
    chk({"R2 rsp_valid ", req}, {31'd0, rsp_valid}, {31'd0, lk});
    if (lk) begin
      chk({req, " hit"},     {31'd0, rsp_hit},     {31'd0, e_hit});
      chk({req, " paddr"},   rsp_paddr,            e_paddr);
      chk({req, " perm_ok"}, {31'd0, rsp_perm_ok}, {31'd0, e_ok});
    end
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(1, la, 0, 0, 0, 2'd0, 0, '0, '0, '0, 0, req);
  endtask

  task automatic fill(input logic [19:0] p, input logic [19:0] f, input logic [3:0] m);
    step(0, '0, 0, 0, 0, 2'd0, 1, p, f, m, 0, "fill");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < DEPTH; j++) begin
      m_tag[j] = '1; m_frame[j] = '0; m_perm[j] = '0;
    end
    m_gen = int'(GINIT); m_busy = 1; m_cnt = DEPTH;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 reset busy", {31'd0, busy}, 32'd1);
    chk("R1 reset fill_ready", {31'd0, fill_ready}, 32'd0);
    chk("R2 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    // R1 / R9: rewrite after reset; fill and flush attempts are ignored
    for (int i = 0; i < DEPTH; i++)
      step(1, {pg(i, 0), 12'h010}, 0, 0, 0, 2'd0, (i == 3), pg(3, 0), fr(3, 0), 4'hF,
           (i == 5), "R9 lookup while busy");
    for (int i = 0; i < DEPTH; i++) look({pg(i, 0), 12'h020}, "R1 empty after reset");

    // R3/R4/R5: fill every slot, then sweep access kinds
    for (int i = 0; i < DEPTH; i++) fill(pg(i, 0), fr(i, 0), 4'(i));
    for (int i = 0; i < DEPTH; i++)
      for (int c = 0; c < 8; c++)
        step(1, {pg(i, 0), 12'((i * 12'h0F3) & 12'hFF0)}, c[0], c[1], c[2], 2'(c & 3),
             0, '0, '0, '0, 0, "R3/R4/R5 sweep");

    // R6: page-crossing limits per size
    for (int s = 0; s < 4; s++) begin
      step(1, {pg(2, 0), 12'(4096 - (1 << s))}, 0, 0, 0, 2'(s), 0, '0, '0, '0, 0, "R6 at limit");
      step(1, {pg(2, 0), 12'h000}, 0, 0, 0, 2'(s), 0, '0, '0, '0, 0, "R6 offset zero");
      if (s > 0)
        step(1, {pg(2, 0), 12'(4097 - (1 << s))}, 0, 0, 0, 2'(s), 0, '0, '0, '0, 0, "R6 past limit");
    end

    // R3: other page in the same slot misses, then replaces
    look({pg(5, 1), 12'h444}, "R3 alias miss");
    fill(pg(5, 1), fr(5, 1), 4'h3);
    look({pg(5, 1), 12'h444}, "R3 alias hit");
    look({pg(5, 0), 12'h444}, "R3 replaced miss");

    // R10: lookup and fill to the same slot in one cycle
    step(1, {pg(6, 0), 12'h123}, 0, 1, 0, 2'd0, 1, pg(6, 1), fr(6, 1), 4'hA, 0, "R10 fill+lookup old");
    look({pg(6, 1), 12'h123}, "R10 new entry hit");
    look({pg(6, 0), 12'h123}, "R10 old entry gone");

    // R7 / R10: lookup alongside a flush, then everything misses
    step(1, {pg(7, 0), 12'h0AB}, 1, 1, 0, 2'd1, 0, '0, '0, '0, 1, "R10 flush+lookup");
    for (int i = 0; i < DEPTH; i++) look({pg(i, 0), 12'h008}, "R7 flushed");
    look({pg(5, 1), 12'h008}, "R7 flushed alias");

    // R10: fill together with a flush is dead at once
    step(0, '0, 0, 0, 0, 2'd0, 1, pg(8, 2), fr(8, 2), 4'hF, 1, "R10 fill+flush");
    look({pg(8, 2), 12'h100}, "R10 fill with flush misses");
    fill(pg(9, 3), fr(9, 3), 4'h5);
    look({pg(9, 3), 12'h200}, "R7 fill after flush hits");

    // R8: wrapping flush rewrites all slots; stale first-round tags must not return
    step(0, '0, 0, 0, 0, 2'd0, 0, '0, '0, '0, 1, "R8 wrap flush");
    for (int i = 0; i < DEPTH; i++)
      step(1, {pg(9, 3), 12'h200}, 0, 0, 0, 2'd0, (i == 1), pg(10, 0), fr(10, 0), 4'hF,
           (i == 2), "R9 miss during rewrite");
    for (int i = 0; i < DEPTH; i++) look({pg(i, 0), 12'h030}, "R8 stale tag after wrap");
    fill(pg(11, 0), fr(11, 0), 4'h9);
    look({pg(11, 0), 12'h7FF}, "R8 fill after wrap hits");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule